// File: doc/BRIEF.md
# Cache Line Range Maintenance Engine

This engine sits between a processor's maintenance register writes and a cache tag/data array. A range operation is written as two successive register writes: first the start address, then an end address whose command code picks clean or invalidate. The end write launches a walk over every cache line whose first byte lies in the inclusive window [start, end]. The engine issues one command per line on a valid/ready port and holds the stall output high until the last line is accepted.

The same command interface also carries single-line clean, invalidate and clean-plus-invalidate requests, and an invalidate-all sweep that steps through every set/way index. A range must stay inside one 4 KiB page, because only the start address is translated upstream. A range that crosses a page is rejected with an error and issues no line commands. A range that contains no line finishes at once.

Top module: `line_maint_engine`

## Requirements
- R1: After reset, stall_o, done_o, err_o and arr_valid_o are all low, and the latched start address is 0.
- R2: Command code 0 latches cmd_data_i as the start address. Code 1 launches a clean range (arr_kind_o = 0). Code 2 launches an invalidate range (arr_kind_o = 1). Both use the latched start and take cmd_data_i as the inclusive end.
- R3: A range issues exactly the lines from start rounded up to 32 bytes through end rounded down to 32 bytes, in ascending order, with the address stepping by 32. Every issued address has its low 5 bits at 0.
- R4: stall_o is high from the cycle after a launching write until the last command is accepted. In the cycle after that acceptance, done_o pulses for one cycle and stall_o is low.
- R5: If start and end differ in any address bit at or above bit 12, the range is rejected. In the cycle after the end write, done_o and err_o pulse together, and no line command is issued.
- R6: If a range on one page holds no line (end below start, or no line start in the window), done_o pulses in the cycle after the end write, err_o stays low, and no line command is issued.
- R7: Codes 3, 4 and 5 each issue one command at cmd_data_i rounded down to 32 bytes, with arr_kind_o 0 (clean), 1 (invalidate) and 2 (clean and invalidate) respectively.
- R8: Code 6 issues SETS*WAYS commands with arr_by_idx_o high, arr_kind_o = 1 and arr_idx_o going 0, 1, ... up to the final index, then signals done_o.
- R9: An end write that has no preceding start write uses the most recently latched start value, which is 0 after reset.
- R10: A command is held with a stable address, index and kind until arr_ready_i is seen high. The walk advances only on a cycle where valid and ready are both high.
- R11: Any command presented while stall_o is high is ignored, including a start write, so the latched start is unchanged. Code 7 is ignored at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Register write strobe |
| cmd_op_i | input | 3 | Command code |
| cmd_data_i | input | ADDR_W | Address operand |
| stall_o | output | 1 | Requester stall while a walk is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle page-crossing rejection pulse |
| arr_valid_o | output | 1 | Line command valid |
| arr_ready_i | input | 1 | Array accepts the command |
| arr_by_idx_o | output | 1 | Command addresses a set/way index, not an address |
| arr_kind_o | output | 2 | 0 clean, 1 invalidate, 2 clean and invalidate |
| arr_addr_o | output | ADDR_W | Line address |
| arr_idx_o | output | IDX_W | Set/way index for invalidate-all |

## Verification
The assertions assume that the array's ready input is a free choice in each cycle and that command writes may arrive at any time, including during a stall. The stall case is checked at the ports and is not assumed away. The stimulus holds ready low for stretches, randomises ready per cycle, and deliberately writes commands while the engine is stalled. Range endpoints are drawn so that most ranges fall within one page, with a share crossing a page or ending below the start. This keeps the alignment, page and stepping properties exercised on both their accepting and rejecting sides.

// File: rtl/lme_pkg.sv
package lme_pkg;
  typedef enum logic [2:0] {
    OP_SET_START  = 3'd0,
    OP_CLEAN_END  = 3'd1,
    OP_INV_END    = 3'd2,
    OP_LINE_CLEAN = 3'd3,
    OP_LINE_INV   = 3'd4,
    OP_LINE_FLUSH = 3'd5,
    OP_INV_ALL    = 3'd6,
    OP_RSVD       = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    K_CLEAN = 2'd0,
    K_INV   = 2'd1,
    K_FLUSH = 2'd2
  } kind_e;
endpackage

// File: rtl/lme_decode.sv
module lme_decode
  import lme_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned PAGE_BYTES = 4096
) (
  input  logic              cmd_valid_i,
  input  logic              idle_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] data_i,
  input  logic [ADDR_W-1:0] start_i,
  output logic              set_start_o,
  output logic              launch_o,
  output logic              finish_o,
  output logic              err_o,
  output logic              by_idx_o,
  output logic [1:0]        kind_o,
  output logic [ADDR_W-1:0] first_o,
  output logic [ADDR_W-1:0] last_o
);
  localparam int unsigned LB = $clog2(LINE_BYTES);
  localparam int unsigned PB = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] LMASK = ~ADDR_W'(LINE_BYTES - 1);

  logic [ADDR_W:0]   rng_first_ext;
  logic [ADDR_W-1:0] rng_first, rng_last, line_addr;
  logic              page_diff, rng_empty;

  // first line start at or above start, may overflow past the top
  assign rng_first_ext = ({1'b0, start_i} + (ADDR_W+1)'(LINE_BYTES - 1)) & {1'b1, LMASK};
  assign rng_first     = rng_first_ext[ADDR_W-1:0];
  assign rng_last      = data_i & LMASK;
  assign line_addr     = data_i & LMASK;
  assign page_diff     = start_i[ADDR_W-1:PB] != data_i[ADDR_W-1:PB];
  assign rng_empty     = rng_first_ext[ADDR_W] || (rng_first > rng_last);

  always_comb begin
    set_start_o = 1'b0;
    launch_o    = 1'b0;
    finish_o    = 1'b0;
    err_o       = 1'b0;
    by_idx_o    = 1'b0;
    kind_o      = K_CLEAN;
    first_o     = line_addr;
    last_o      = line_addr;
    if (cmd_valid_i && idle_i) begin
      unique case (op_e'(op_i))
        OP_SET_START: set_start_o = 1'b1;
        OP_CLEAN_END, OP_INV_END: begin
          kind_o  = (op_e'(op_i) == OP_CLEAN_END) ? K_CLEAN : K_INV;
          first_o = rng_first;
          last_o  = rng_last;
          if (page_diff) begin
            finish_o = 1'b1;
            err_o    = 1'b1;
          end else if (rng_empty) begin
            finish_o = 1'b1;
          end else begin
            launch_o = 1'b1;
          end
        end
        OP_LINE_CLEAN: launch_o = 1'b1;
        OP_LINE_INV: begin
          launch_o = 1'b1;
          kind_o   = K_INV;
        end
        OP_LINE_FLUSH: begin
          launch_o = 1'b1;
          kind_o   = K_FLUSH;
        end
        OP_INV_ALL: begin
          launch_o = 1'b1;
          by_idx_o = 1'b1;
          kind_o   = K_INV;
        end
        default: ;
      endcase
    end
  end

  logic unused_lb;
  assign unused_lb = ^LB;
endmodule

// File: rtl/lme_walker.sv
module lme_walker
  import lme_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned NUM_IDX    = 256,
  parameter int unsigned IDX_W      = $clog2(NUM_IDX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              finish_i,
  input  logic              err_i,
  input  logic              by_idx_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] first_i,
  input  logic [ADDR_W-1:0] last_i,
  input  logic              arr_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              arr_valid_o,
  output logic              arr_by_idx_o,
  output logic [1:0]        arr_kind_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [IDX_W-1:0]  arr_idx_o
);
  localparam int unsigned LB = $clog2(LINE_BYTES);
  localparam int unsigned PB = $clog2(PAGE_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_IDX - 1);

  logic              busy_q, by_idx_q, done_q, err_q;
  logic [1:0]        kind_q;
  logic [ADDR_W-1:0] cur_q, last_q;
  logic [IDX_W-1:0]  idx_q;
  logic              fire, at_end;

  assign fire   = busy_q && arr_ready_i;
  assign at_end = by_idx_q ? (idx_q == IDX_LAST) : (cur_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      by_idx_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      kind_q   <= K_CLEAN;
      cur_q    <= '0;
      last_q   <= '0;
      idx_q    <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy_q) begin
        if (launch_i) begin
          busy_q   <= 1'b1;
          by_idx_q <= by_idx_i;
          kind_q   <= kind_i;
          cur_q    <= first_i;
          last_q   <= last_i;
          idx_q    <= '0;
        end else if (finish_i) begin
          done_q <= 1'b1;
          err_q  <= err_i;
        end
      end else if (fire) begin
        if (at_end) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (by_idx_q) begin
          idx_q <= idx_q + 1'b1;
        end else begin
          cur_q <= cur_q + ADDR_W'(LINE_BYTES);
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign arr_valid_o  = busy_q;
  assign arr_by_idx_o = by_idx_q;
  assign arr_kind_o   = kind_q;
  assign arr_addr_o   = cur_q;
  assign arr_idx_o    = idx_q;

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_valid_o && !arr_ready_i |=> arr_valid_o && $stable(arr_addr_o)
      && $stable(arr_idx_o) && $stable(arr_kind_o) && $stable(arr_by_idx_o));
  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !at_end && !by_idx_q |=> arr_addr_o == $past(arr_addr_o) + ADDR_W'(LINE_BYTES));
  p_aligned_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_valid_o && !arr_by_idx_o |-> arr_addr_o[LB-1:0] == '0);
  p_one_page_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_valid_o && !arr_by_idx_o |-> cur_q[ADDR_W-1:PB] == last_q[ADDR_W-1:PB]);
  p_idx_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !at_end && by_idx_q |=> arr_idx_o == $past(arr_idx_o) + 1'b1);
  p_idx_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_valid_o && arr_by_idx_o |-> arr_idx_o <= IDX_LAST);
  p_done_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_err_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o && !$past(busy_o));
endmodule

// File: rtl/line_maint_engine.sv
module line_maint_engine
  import lme_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned SETS       = 64,
  parameter int unsigned WAYS       = 4,
  localparam int unsigned NUM_IDX   = SETS * WAYS,
  localparam int unsigned IDX_W     = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_data_i,
  output logic              stall_o,
  output logic              done_o,
  output logic              err_o,
  output logic              arr_valid_o,
  input  logic              arr_ready_i,
  output logic              arr_by_idx_o,
  output logic [1:0]        arr_kind_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [IDX_W-1:0]  arr_idx_o
);
  logic [ADDR_W-1:0] start_q, first, last;
  logic              set_start, launch, finish, dec_err, by_idx, busy;
  logic [1:0]        kind;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        start_q <= '0;
    else if (set_start) start_q <= cmd_data_i;
  end

  lme_decode #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES)
  ) u_decode (
    .cmd_valid_i(cmd_valid_i),
    .idle_i     (!busy),
    .op_i       (cmd_op_i),
    .data_i     (cmd_data_i),
    .start_i    (start_q),
    .set_start_o(set_start),
    .launch_o   (launch),
    .finish_o   (finish),
    .err_o      (dec_err),
    .by_idx_o   (by_idx),
    .kind_o     (kind),
    .first_o    (first),
    .last_o     (last)
  );

  lme_walker #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES),
    .NUM_IDX(NUM_IDX), .IDX_W(IDX_W)
  ) u_walker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .finish_i    (finish),
    .err_i       (dec_err),
    .by_idx_i    (by_idx),
    .kind_i      (kind),
    .first_i     (first),
    .last_i      (last),
    .arr_ready_i (arr_ready_i),
    .busy_o      (busy),
    .done_o      (done_o),
    .err_o       (err_o),
    .arr_valid_o (arr_valid_o),
    .arr_by_idx_o(arr_by_idx_o),
    .arr_kind_o  (arr_kind_o),
    .arr_addr_o  (arr_addr_o),
    .arr_idx_o   (arr_idx_o)
  );

  assign stall_o = busy;

  p_one_action_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({set_start, launch, finish}));
  p_stall_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(start_q));
  p_launch_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> stall_o);
  p_reject_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish |=> done_o && !arr_valid_o);
endmodule

// File: tb/sim_line_maint_engine.sv
module sim_line_maint_engine;
  localparam int CLK_NS = 10;
  localparam int AW = 32;
  localparam int NIDX = 256;
  localparam int IW = 8;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_data = '0;
  logic          arr_ready = 1'b0;
  logic          stall, done, err, arr_valid, arr_by_idx;
  logic [1:0]    arr_kind;
  logic [AW-1:0] arr_addr;
  logic [IW-1:0] arr_idx;

  line_maint_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_data_i(cmd_data), .stall_o(stall), .done_o(done), .err_o(err),
    .arr_valid_o(arr_valid), .arr_ready_i(arr_ready), .arr_by_idx_o(arr_by_idx),
    .arr_kind_o(arr_kind), .arr_addr_o(arr_addr), .arr_idx_o(arr_idx)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit rdy_hold = 1'b0;
  logic [AW-1:0] m_start = '0;

  logic [AW-1:0] exp_a [512];
  logic [1:0]    exp_k [512];
  bit            exp_x [512];
  int            exp_n;
  bit            exp_err, exp_launch;
  logic [AW-1:0] log_a [512];
  logic [1:0]    log_k [512];
  bit            log_x [512];
  int            log_n = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // ready driven at negedge; handshake recorded for the next rising edge
  always @(negedge clk) begin
    arr_ready = rdy_hold ? 1'b0 : (($urandom % 4) != 0);
    #1;
    if (arr_valid && arr_ready && log_n < 512) begin
      log_a[log_n] = arr_by_idx ? AW'(arr_idx) : arr_addr;
      log_k[log_n] = arr_kind;
      log_x[log_n] = arr_by_idx;
      log_n++;
    end
  end

  function automatic void push(input logic [AW-1:0] a, input logic [1:0] k, input bit x);
    exp_a[exp_n] = a; exp_k[exp_n] = k; exp_x[exp_n] = x; exp_n++;
  endfunction

  function automatic void model(input logic [2:0] op, input logic [AW-1:0] d);
    logic [AW:0] f;
    logic [AW:0] l;
    exp_n = 0; exp_err = 0; exp_launch = 0;
    case (op)
      3'd1, 3'd2: begin
        if (m_start[AW-1:12] != d[AW-1:12]) exp_err = 1;
        else begin
          f = (AW+1)'(m_start) + 33'd31; f[4:0] = '0;
          l = (AW+1)'(d); l[4:0] = '0;
          for (logic [AW:0] a = f; a <= l; a += 33'd32)
            push(a[AW-1:0], (op == 3'd1) ? 2'd0 : 2'd1, 1'b0);
        end
      end
      3'd3, 3'd4, 3'd5: push({d[AW-1:5], 5'b0}, 2'(op - 3'd3), 1'b0);
      3'd6: for (int i = 0; i < NIDX; i++) push(AW'(i), 2'd1, 1'b1);
      default: ;
    endcase
    exp_launch = (exp_n != 0);
  endfunction

  task automatic issue(input logic [2:0] op, input logic [AW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // wait for done starting at the negedge after the write; check result
  task automatic finish_check(input string req);
    bit seen = 0, stall_ok = 1, stall_done = 0, err_seen = 0;
    bit list_ok;
    for (int c = 0; c < 2000; c++) begin
      #2;
      if (done) begin seen = 1; err_seen = err; stall_done = stall; break; end
      if (exp_launch && !stall) stall_ok = 0;
      @(negedge clk);
    end
    chk(seen, {req, " done pulse"}, seen, 1);
    chk(err_seen == exp_err, {req, " R5 err flag"}, err_seen, exp_err);
    chk(stall_ok && !stall_done, {req, " R4 stall window"}, stall_done, 0);
    chk(log_n == exp_n, {req, " command count"}, log_n, exp_n);
    list_ok = 1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (log_a[i] != exp_a[i] || log_k[i] != exp_k[i] || log_x[i] != exp_x[i]) begin
        if (list_ok) chk(0, {req, " command list"}, log_a[i], exp_a[i]);
        list_ok = 0;
      end
    if (list_ok) chk(1, req, 0, 0);
  endtask

  task automatic run(input logic [2:0] op, input logic [AW-1:0] d, input string req);
    if (op == 3'd0) begin
      issue(op, d); m_start = d; return;
    end
    model(op, d);
    log_n = 0;
    issue(op, d);
    finish_check(req);
  endtask

  bit wd_hit = 0;
  initial begin
    #(CLK_NS * 150000);
    wd_hit = 1;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] hold_a;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!stall && !done && !err && !arr_valid, "R1 reset outputs", {stall, done, err, arr_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!stall && !arr_valid, "R1 idle after reset", {stall, arr_valid}, 0);

    run(3'd1, 32'h0000_0060, "R9 end without start");
    run(3'd0, 32'h0000_1005, "R2");
    run(3'd1, 32'h0000_1047, "R3 R2 clean range unaligned");
    run(3'd2, 32'h0000_1040, "R3 R2 invalidate range");
    run(3'd0, 32'h0000_1FF0, "R5");
    run(3'd1, 32'h0000_2000, "R5 page cross");
    run(3'd0, 32'h0000_3100, "R6");
    run(3'd2, 32'h0000_30FF, "R6 end below start");
    run(3'd0, 32'h0000_3FE1, "R6");
    run(3'd1, 32'h0000_3FFF, "R6 no line start in window");
    run(3'd0, 32'h0000_4FE0, "R3");
    run(3'd2, 32'h0000_4FFF, "R3 last line of page");
    run(3'd0, 32'h0000_5000, "R3");
    run(3'd1, 32'h0000_5FFF, "R3 full page");
    run(3'd3, 32'h0000_7013, "R7 clean line");
    run(3'd4, 32'h0000_703F, "R7 invalidate line");
    run(3'd5, 32'h0000_7040, "R7 clean and invalidate line");
    run(3'd6, 32'h0, "R8 invalidate all");

    // R10: hold ready low and watch the command stay put
    rdy_hold = 1'b1;
    model(3'd5, 32'h0000_8124); log_n = 0;
    issue(3'd5, 32'h0000_8124);
    #2 hold_a = arr_addr;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk); #2;
      chk(arr_valid && arr_addr == hold_a && arr_kind == 2'd2, "R10 hold while not ready", arr_addr, hold_a);
    end
    rdy_hold = 1'b0;
    finish_check("R10 release");

    // R11: writes during a stall are ignored
    run(3'd0, 32'h0000_9000, "R11");
    model(3'd2, 32'h0000_93FF); log_n = 0;
    issue(3'd2, 32'h0000_93FF);
    cmd_valid = 1'b1; cmd_op = 3'd0; cmd_data = 32'h0000_9800;
    repeat (4) @(negedge clk);
    cmd_op = 3'd3; cmd_data = 32'h0000_9F00;
    @(negedge clk);
    cmd_valid = 1'b0;
    finish_check("R11 stalled writes dropped");
    run(3'd1, 32'h0000_903F, "R11 start kept across stall");
    log_n = 0;
    issue(3'd7, 32'h0000_9000);
    repeat (3) begin
      #2;
      chk(!stall && !done && log_n == 0, "R11 reserved code ignored", {stall, done}, 0);
      @(negedge clk);
    end

    // random mix
    for (int it = 0; it < 80; it++) begin
      logic [AW-1:0] pg, s, e;
      int sel;
      pg  = {$urandom, 12'h000} & 32'hFFFF_F000;
      s   = pg | ($urandom % 4096);
      sel = $urandom % 10;
      if (sel < 6)      e = pg | ((s[11:0] + ($urandom % 1024)) & 12'hFFF);
      else if (sel < 8) e = s + 32'h1000;
      else              e = pg | ($urandom % 4096);
      if ($urandom % 4 != 0) run(3'd0, s, "R2");
      if (sel == 9)      run(3'($urandom % 3 + 3), e, "R7 random line");
      else if ($urandom % 40 == 0) run(3'd6, 0, "R8 random");
      else               run(($urandom % 2) ? 3'd1 : 3'd2, e, "R3 random range");
    end

    if (!wd_hit) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule